// File: doc/BRIEF.md
# Parallel NOR Flash Command Interpreter

This block sits behind the bus port of a byte-wide parallel NOR-flash model and turns host writes into operations. Each host write arrives as a one-cycle strobe with a 21-bit byte address and a data byte. The block follows the unlock handshakes and recognises byte program, sector erase, block erase, whole-array erase, erase suspend and resume, query-mode entry, security-ID entry and the exit command.

It starts work in a separate operation sequencer with one-cycle start pulses that carry the target address, data and erase kind. It hears back from that sequencer through a done strobe. A hardware write-protect input guards one 64 KByte boot block, which is either the highest or the lowest block depending on a parameter. The block reports one mode code that the read path uses to choose what to return: array data, query/ID data, security-ID data, busy status or suspended status.

Top module: `flash_cmd_decoder`

## Requirements
- R1: A synchronous active-high reset, at any time, abandons any running operation and any partial sequence and leaves mode = 0 (read) with every pulse output low.
- R2: Writes AAH@AAAH, 55H@555H, A0H@AAAH and then one write (A, D) raise prog_start for exactly the cycle after that fourth write, with op_addr = A and op_data = D. Command addresses are compared on address bits [11:0] only.
- R3: Writes AAH@AAAH, 55H@555H, 80H@AAAH, AAH@AAAH, 55H@555H, then a sixth write raise erase_start for one cycle. A sixth write of 50H at A gives erase_kind 0 (4 KByte sector) and op_addr = A. A sixth write of 30H at A gives erase_kind 1 (64 KByte block) and op_addr = A. A sixth write of 10H at AAAH gives erase_kind 2 (whole array) and op_addr = 0. A sixth write of 10H at any other address starts nothing.
- R4: A write that does not fit the sequence in progress, or that starts no known command, abandons the sequence and sets mode 0. This also leaves query and security-ID modes. The next sequence is then decoded from its first write.
- R5: A third write of 98H@AAAH gives mode 1 (query/ID). A third write of 88H@AAAH gives mode 2 (security ID). A single F0H write at any address at the start of a sequence gives mode 0, and so does F0H@AAAH as the third write.
- R6: From a start pulse until op_done, mode is 3 (busy) and every write is dropped, the exit command included, apart from the suspend command of R9. When the operation ends, the earlier mode (0, 1 or 2) returns.
- R7: With wp_n low, a program, sector erase or block erase whose address lies in the boot block is dropped without a start pulse. The boot block is address bits [20:16] = 1FH when BOOT_TOP = 1 and 00H when BOOT_TOP = 0. With wp_n high, every block is accepted.
- R8: With wp_n low, a whole-array erase is dropped.
- R9: A single B0H write at any address while a sector or block erase runs raises suspend_req for one cycle and sets mode 4 (suspended). A B0H write during a program or a whole-array erase has no effect.
- R10: While mode is 4, a single 30H write at the start of a sequence raises resume_req for one cycle and sets mode 3. op_done has no effect while mode is 4.
- R11: While mode is 4, a byte program is accepted unless it targets the suspended sector (sector erase) or the suspended block (block erase). An accepted program shows mode 3 and returns to mode 4 on op_done.
- R12: At most one of prog_start, erase_start, suspend_req and resume_req is high in any cycle, and a start pulse is always seen together with mode 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| wr_addr | input | 21 | Byte address of the write |
| wr_data | input | 8 | Data byte of the write |
| wp_n | input | 1 | Boot-block write protect, active low |
| op_done | input | 1 | Sequencer reports that the running operation has finished |
| prog_start | output | 1 | Start a byte program |
| erase_start | output | 1 | Start an erase |
| erase_kind | output | 2 | 0 sector, 1 block, 2 whole array |
| op_addr | output | 21 | Target address of the started operation |
| op_data | output | 8 | Data byte of the started program |
| suspend_req | output | 1 | Suspend the running erase |
| resume_req | output | 1 | Resume the suspended erase |
| mode | output | 3 | 0 read, 1 query/ID, 2 security ID, 3 busy, 4 suspended |

## Verification
Protection is swept over all 32 blocks for both levels of wp_n, once with programs and once with sector erases. This separates the boot block from its neighbours and shows that wp_n has no effect when high. Programs use varied address and data patterns, and some unlock writes carry high address bits set, so that the 12-bit command-address compare is exercised. Suspend is tried in both sector and block granularity, with programs inside and just outside the suspended region. Separate cases issue suspend during a program and during a whole-array erase, send the exit command while busy, break sequences at their second, third and sixth writes, and assert reset during an operation.

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int AW       = 21,
  parameter int SECT_W   = 12,
  parameter int BLK_W    = 16,
  parameter int CMD_AW   = 12,
  parameter bit BOOT_TOP = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          wp_n,
  input  logic          op_done,
  output logic          prog_start,
  output logic          erase_start,
  output logic [1:0]    erase_kind,
  output logic [AW-1:0] op_addr,
  output logic [7:0]    op_data,
  output logic          suspend_req,
  output logic          resume_req,
  output logic [2:0]    mode
);
  localparam int BN_W = AW - BLK_W;
  localparam logic [CMD_AW-1:0] A_HI = CMD_AW'('hAAA);
  localparam logic [CMD_AW-1:0] A_LO = CMD_AW'('h555);
  localparam logic [BN_W-1:0] BOOT_BLK = BOOT_TOP ? {BN_W{1'b1}} : {BN_W{1'b0}};

  typedef enum logic [2:0] {SQ_IDLE, SQ_U1, SQ_U2, SQ_PA, SQ_E1, SQ_E2, SQ_E3} seq_t;
  typedef enum logic [2:0] {OP_NONE, OP_PROG, OP_ERASE, OP_CHIP, OP_SUSP, OP_SPROG} op_t;

  seq_t          seq;
  op_t           op;
  logic [1:0]    rmode;
  logic [AW-1:0] susp_addr;
  logic          susp_blk;

  wire at_hi     = wr_addr[CMD_AW-1:0] == A_HI;
  wire at_lo     = wr_addr[CMD_AW-1:0] == A_LO;
  wire busy      = (op == OP_PROG) || (op == OP_ERASE) || (op == OP_CHIP) || (op == OP_SPROG);
  wire suspended = op == OP_SUSP;
  wire locked    = !wp_n && (wr_addr[AW-1:BLK_W] == BOOT_BLK);
  wire hits_susp = susp_blk ? (wr_addr[AW-1:BLK_W] == susp_addr[AW-1:BLK_W])
                            : (wr_addr[AW-1:SECT_W] == susp_addr[AW-1:SECT_W]);

  assign mode = busy ? 3'd3 : suspended ? 3'd4 : {1'b0, rmode};

  always_ff @(posedge clk) begin
    if (rst) begin
      seq <= SQ_IDLE;
      op <= OP_NONE;
      rmode <= 2'd0;
      susp_addr <= '0;
      susp_blk <= 1'b0;
      prog_start <= 1'b0;
      erase_start <= 1'b0;
      erase_kind <= 2'd0;
      op_addr <= '0;
      op_data <= 8'h00;
      suspend_req <= 1'b0;
      resume_req <= 1'b0;
    end else begin
      prog_start <= 1'b0;
      erase_start <= 1'b0;
      suspend_req <= 1'b0;
      resume_req <= 1'b0;
      if (op_done) begin
        case (op)
          OP_PROG, OP_ERASE, OP_CHIP: op <= OP_NONE;
          OP_SPROG:                   op <= OP_SUSP;
          default:                    ;
        endcase
      end
      if (wr_en) begin
        if (busy) begin
          if (op == OP_ERASE && wr_data == 8'hB0 && !op_done) begin
            op <= OP_SUSP;
            suspend_req <= 1'b1;
          end
        end else begin
          seq <= SQ_IDLE;
          case (seq)
            SQ_IDLE: begin
              if (at_hi && wr_data == 8'hAA) seq <= SQ_U1;
              else if (suspended && wr_data == 8'h30) begin
                op <= OP_ERASE;
                resume_req <= 1'b1;
              end else rmode <= 2'd0;
            end
            SQ_U1: begin
              if (at_lo && wr_data == 8'h55) seq <= SQ_U2;
              else rmode <= 2'd0;
            end
            SQ_U2: begin
              if (!at_hi) rmode <= 2'd0;
              else case (wr_data)
                8'hA0: seq <= SQ_PA;
                8'h80: if (!suspended) seq <= SQ_E1; else rmode <= 2'd0;
                8'h98: rmode <= suspended ? 2'd0 : 2'd1;
                8'h88: rmode <= suspended ? 2'd0 : 2'd2;
                default: rmode <= 2'd0;
              endcase
            end
            SQ_PA: begin
              if (!locked && !(suspended && hits_susp)) begin
                prog_start <= 1'b1;
                op_addr <= wr_addr;
                op_data <= wr_data;
                op <= suspended ? OP_SPROG : OP_PROG;
              end
            end
            SQ_E1: begin
              if (at_hi && wr_data == 8'hAA) seq <= SQ_E2;
              else rmode <= 2'd0;
            end
            SQ_E2: begin
              if (at_lo && wr_data == 8'h55) seq <= SQ_E3;
              else rmode <= 2'd0;
            end
            SQ_E3: begin
              if (wr_data == 8'h50 || wr_data == 8'h30) begin
                if (!locked) begin
                  erase_start <= 1'b1;
                  erase_kind <= (wr_data == 8'h30) ? 2'd1 : 2'd0;
                  op_addr <= wr_addr;
                  susp_addr <= wr_addr;
                  susp_blk <= wr_data == 8'h30;
                  op <= OP_ERASE;
                end
              end else if (wr_data == 8'h10 && at_hi) begin
                if (wp_n) begin
                  erase_start <= 1'b1;
                  erase_kind <= 2'd2;
                  op_addr <= '0;
                  op <= OP_CHIP;
                end
              end else rmode <= 2'd0;
            end
            default: rmode <= 2'd0;
          endcase
        end
      end
    end
  end

  a_r12_one_pulse: assert property (@(posedge clk) disable iff (rst)
    $onehot0({prog_start, erase_start, suspend_req, resume_req}));
  a_r12_start_busy: assert property (@(posedge clk) disable iff (rst)
    (prog_start || erase_start) |-> mode == 3'd3);
  a_r6_busy_drops: assert property (@(posedge clk) disable iff (rst)
    (busy && !op_done) |=> !prog_start && !erase_start && !resume_req);
  a_r8_chip_wp: assert property (@(posedge clk) disable iff (rst)
    (erase_start && erase_kind == 2'd2) |-> $past(wp_n));
  a_r7_boot_prog: assert property (@(posedge clk) disable iff (rst)
    (prog_start || (erase_start && erase_kind != 2'd2)) |->
      ($past(wp_n) || op_addr[AW-1:BLK_W] != BOOT_BLK));
  a_r9_susp_mode: assert property (@(posedge clk) disable iff (rst)
    suspend_req |-> mode == 3'd4);
  a_r10_resume: assert property (@(posedge clk) disable iff (rst)
    resume_req |-> (mode == 3'd3 && $past(mode) == 3'd4));
  a_r10_mode_range: assert property (@(posedge clk) disable iff (rst)
    mode <= 3'd4);
endmodule

// File: tb/tb_flash_cmd_decoder.sv
module tb_flash_cmd_decoder;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [20:0] wr_addr = '0;
  logic [7:0] wr_data = 8'h00;
  logic wp_n = 1'b1;
  logic op_done = 1'b0;
  logic prog_start, erase_start, suspend_req, resume_req;
  logic [1:0] erase_kind;
  logic [20:0] op_addr;
  logic [7:0] op_data;
  logic [2:0] mode;
  int nchk = 0;
  int nerr = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  flash_cmd_decoder dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wp_n(wp_n), .op_done(op_done), .prog_start(prog_start), .erase_start(erase_start),
    .erase_kind(erase_kind), .op_addr(op_addr), .op_data(op_data),
    .suspend_req(suspend_req), .resume_req(resume_req), .mode(mode));

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [20:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic unlock3(input logic [7:0] d);
    wr(21'h000AAA, 8'hAA); wr(21'h000555, 8'h55); wr(21'h000AAA, d);
  endtask

  task automatic prog(input logic [20:0] a, input logic [7:0] d);
    unlock3(8'hA0); wr(a, d);
  endtask

  task automatic erase6(input logic [20:0] a, input logic [7:0] d);
    unlock3(8'h80); wr(21'h000AAA, 8'hAA); wr(21'h000555, 8'h55); wr(a, d);
  endtask

  task automatic done();
    @(negedge clk); op_done = 1'b1;
    @(negedge clk); op_done = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset mode", mode, 0);
    chk("R1 reset pulses", {prog_start, erase_start, suspend_req, resume_req}, 0);

    // R2 program with varied patterns, unlock addresses with upper bits set
    for (int i = 0; i < 16; i++) begin
      logic [20:0] a = 21'(i * 21'h01_3579 + 7);
      logic [7:0] d = 8'(i * 37 + 1);
      wr(21'h1F0AAA, 8'hAA); wr(21'h0A5555, 8'h55); wr(21'h123AAA, 8'hA0); wr(a, d);
      chk("R2 prog_start", prog_start, 1);
      chk("R2 op_addr", op_addr, a);
      chk("R2 op_data", op_data, d);
      chk("R6 busy mode", mode, 3);
      @(negedge clk);
      chk("R12 pulse one cycle", prog_start, 0);
      done();
      chk("R6 mode after done", mode, 0);
    end

    // R3 erase kinds
    erase6(21'h0A3123, 8'h50);
    chk("R3 sector start", erase_start, 1); chk("R3 sector kind", erase_kind, 0);
    chk("R3 sector addr", op_addr, 21'h0A3123); done();
    erase6(21'h154000, 8'h30);
    chk("R3 block start", erase_start, 1); chk("R3 block kind", erase_kind, 1);
    chk("R3 block addr", op_addr, 21'h154000); done();
    erase6(21'h000AAA, 8'h10);
    chk("R3 chip start", erase_start, 1); chk("R3 chip kind", erase_kind, 2);
    chk("R3 chip addr", op_addr, 0);
    // R9 suspend ignored during chip erase
    wr(21'h000000, 8'hB0);
    chk("R9 no suspend chip", suspend_req, 0); chk("R9 chip still busy", mode, 3);
    done();
    erase6(21'h000ABA, 8'h10);
    chk("R3 chip wrong addr", erase_start, 0); chk("R3 chip wrong addr mode", mode, 0);

    // R7 boot-block sweep (BOOT_TOP=1 -> block 1F)
    for (int w = 0; w < 2; w++) begin
      for (int b = 0; b < 32; b++) begin
        logic [20:0] a = {b[4:0], 16'h2345};
        bit ok = (w == 1) || (b != 31);
        wp_n = w[0];
        prog(a, 8'h5A);
        chk("R7 prog protect", prog_start, int'(ok));
        if (ok) done(); else chk("R7 prog dropped mode", mode, 0);
        erase6(a, 8'h50);
        chk("R7 sector protect", erase_start, int'(ok));
        if (ok) done();
      end
    end
    wp_n = 1'b0;
    erase6(21'h1F8000, 8'h30);
    chk("R7 block protect", erase_start, 0);
    erase6(21'h000AAA, 8'h10);
    chk("R8 chip blocked", erase_start, 0); chk("R8 mode", mode, 0);
    wp_n = 1'b1;

    // R9/R10/R11 sector suspend
    erase6(21'h003000, 8'h50);
    wr(21'h1ABCDE, 8'hB0);
    chk("R9 suspend_req", suspend_req, 1); chk("R9 mode susp", mode, 4);
    done();
    chk("R10 done ignored when suspended", mode, 4);
    prog(21'h003FF0, 8'h11);
    chk("R11 same sector blocked", prog_start, 0); chk("R11 mode", mode, 4);
    prog(21'h004010, 8'h22);
    chk("R11 other sector ok", prog_start, 1); chk("R11 busy", mode, 3);
    wr(21'h000000, 8'hB0);
    chk("R9 no suspend in program", suspend_req, 0);
    done();
    chk("R11 back to suspended", mode, 4);
    wr(21'h07_7777, 8'h30);
    chk("R10 resume_req", resume_req, 1); chk("R10 mode busy", mode, 3);
    done();
    chk("R10 erase done", mode, 0);

    // block suspend
    erase6(21'h025000, 8'h30);
    wr(21'h000000, 8'hB0);
    chk("R9 block suspend", mode, 4);
    prog(21'h02F000, 8'h33);
    chk("R11 same block blocked", prog_start, 0);
    prog(21'h030000, 8'h44);
    chk("R11 next block ok", prog_start, 1);
    done();
    wr(21'h000000, 8'h30); done();
    chk("R10 block resume done", mode, 0);

    // R9 during plain program
    prog(21'h000100, 8'h01);
    wr(21'h000000, 8'hB0);
    chk("R9 no suspend program", suspend_req, 0); chk("R9 prog busy", mode, 3);
    done();

    // R5/R6 query mode, exit dropped while busy
    unlock3(8'h98);
    chk("R5 query mode", mode, 1);
    prog(21'h000200, 8'h02);
    wr(21'h000000, 8'hF0);
    chk("R6 exit dropped busy", mode, 3);
    done();
    chk("R6 query mode restored", mode, 1);
    wr(21'h0F0F0F, 8'hF0);
    chk("R5 single exit", mode, 0);
    unlock3(8'h88);
    chk("R5 secid mode", mode, 2);
    unlock3(8'hF0);
    chk("R5 three-write exit", mode, 0);

    // R4 aborts
    unlock3(8'h98);
    wr(21'h000AAA, 8'hAA); wr(21'h000554, 8'h55);
    chk("R4 abort leaves query", mode, 0);
    prog(21'h000300, 8'h03);
    chk("R4 decode after abort", prog_start, 1); done();
    unlock3(8'h88); wr(21'h000AAA, 8'hAA); wr(21'h000555, 8'h55); wr(21'h000AAA, 8'h77);
    chk("R4 bad third write", mode, 0);
    erase6(21'h000400, 8'h20);
    chk("R4 bad sixth write", erase_start, 0);
    prog(21'h000500, 8'h05);
    chk("R4 decode after bad sixth", prog_start, 1); done();

    // R1 reset during operation
    erase6(21'h040000, 8'h30);
    @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
    chk("R1 reset aborts op", mode, 0);
    wr(21'h000000, 8'h30);
    chk("R1 no resume after reset", resume_req, 0);

    finish_run();
  end
endmodule